// File: doc/BRIEF.md
# Remote Spill Ring Controller

This block lets a switch egress queue overflow into a ring of fixed-size slots kept in a server's memory. The remote side is reached through one-sided remote-memory requests. While the local queue is shallow, arriving packet descriptors pass straight through to egress. Once the queue depth reaches a programmed high mark, the arriving packet is turned into a remote WRITE request aimed at the next free ring slot. From then on, every later packet follows it into the ring until the ring has been emptied, so packets never overtake one another.

Draining begins when the queue depth falls to a programmed low mark. The block then issues one remote READ at a time. Each READ fetches a whole slot. When its response returns with the transport headers already removed, the recovered packet is handed to egress, and the freed request slot lets the next READ go out on the following cycle. Every request carries the opcode, the slot address, the remote queue pair number and the remote access key; the last two come from setup registers.

When the ring is empty, no READ is in flight and nothing is being written, the block falls back to the local path. A packet that arrives while the ring is completely full is dropped, and the block pulses a flag for it.

Top module: `spill_ring_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_valid`, `fwd_valid` and `drop_pulse` are low.
- R2: In local mode, a packet that arrives with `q_depth` below `cfg_hi_thresh` appears on `fwd_*` in the next cycle with `fwd_remote`=0, and no request is made.
- R3: A packet that arrives in local mode with `q_depth` >= `cfg_hi_thresh` switches the block to spill mode. In the next cycle the block emits a WRITE request (`req_op`=0) that carries the packet's id and length, `cfg_qpn` and `cfg_rkey`.
- R4: The slot address of a request is `cfg_base_addr + (offset mod 2^DEPTH_LOG2) * ENTRY_BYTES`. WRITEs use the write offset and READs use the read offset. Each offset starts at 0 and advances by one for every request of its kind.
- R5: In spill mode, every arriving packet goes to the ring whatever the queue depth is.
- R6: In spill mode, when the ring holds unread slots, no READ is in flight and `q_depth` <= `cfg_lo_thresh`, a READ (`req_op`=1) is issued. It has id 0 and length ENTRY_BYTES, a whole slot.
- R7: Once draining has begun, it continues whatever the queue depth is. At most one READ is in flight, and each accepted response allows the next READ in the following cycle while unread slots remain.
- R8: A WRITE takes the request port ahead of a READ that is ready in the same cycle. The READ waits for the next free cycle.
- R9: A response that arrives while a READ is in flight appears on `fwd_*` in the next cycle with `fwd_remote`=1 and the response's id and length. A response that arrives with no READ in flight is ignored and produces no `fwd_valid`.
- R10: A packet that arrives in spill mode when 2^DEPTH_LOG2 slots are unread is dropped. `drop_pulse` is high in the next cycle, and no request or forward is made for it.
- R11: Spill mode ends once the ring is empty, no READ is in flight and no WRITE is being made in that cycle. Packets that are not dropped reach `fwd_*` in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet descriptor arrives this cycle |
| in_pkt_id | input | ID_W | Packet handle |
| in_len | input | LEN_W | Packet length in bytes |
| q_depth | input | QD_W | Current local egress queue depth |
| cfg_hi_thresh | input | QD_W | Depth that starts spilling |
| cfg_lo_thresh | input | QD_W | Depth that starts draining |
| cfg_base_addr | input | ADDR_W | Remote address of ring slot 0 |
| cfg_qpn | input | QPN_W | Remote queue pair number |
| cfg_rkey | input | KEY_W | Remote access key |
| rsp_valid | input | 1 | READ response payload arrives |
| rsp_pkt_id | input | ID_W | Packet handle recovered from the slot |
| rsp_len | input | LEN_W | Original length recovered from the slot |
| req_valid | output | 1 | Request valid |
| req_op | output | 1 | 0 = WRITE, 1 = READ |
| req_addr | output | ADDR_W | Remote slot address |
| req_qpn | output | QPN_W | Queue pair number |
| req_rkey | output | KEY_W | Access key |
| req_pkt_id | output | ID_W | Packet handle (0 for READ) |
| req_len | output | LEN_W | Bytes to move |
| fwd_valid | output | 1 | Packet handed to egress |
| fwd_pkt_id | output | ID_W | Forwarded packet handle |
| fwd_len | output | LEN_W | Forwarded packet length |
| fwd_remote | output | 1 | 1 when the packet came back from the ring |
| drop_pulse | output | 1 | Packet dropped because the ring was full |

## Verification
The bench builds the block with DEPTH_LOG2 = 2, so the ring has four slots, and with ENTRY_BYTES = 2048. With only four slots, a short burst at high depth fills the ring and produces drops, and both offsets wrap past the end of the ring several times within a few hundred cycles, so the modulo addressing is checked after each wrap. The bench's memory model answers READs after a latency that the bench changes during the run, so responses arrive both while writes are streaming in and on otherwise idle cycles. This exercises WRITE priority, the self-clocked READ chain and the return to local mode.

// File: rtl/spill_pkg.sv
package spill_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } rdma_op_e;
endpackage

// File: rtl/spill_ring_ptr.sv
module spill_ring_ptr #(
  parameter int DEPTH_LOG2  = 4,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_adv,
  input  logic              rd_adv,
  input  logic [ADDR_W-1:0] base,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int OFF_W      = DEPTH_LOG2 + 1;
  localparam int DEPTH      = 1 << DEPTH_LOG2;
  localparam bit ENTRY_POW2 = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
  localparam int ENTRY_SH   = $clog2(ENTRY_BYTES);

  logic [OFF_W-1:0] wr_off_q, wr_off_d;
  logic [OFF_W-1:0] rd_off_q, rd_off_d;
  logic [OFF_W-1:0] used;

  always_comb begin
    wr_off_d = wr_off_q + OFF_W'(1);
    rd_off_d = rd_off_q + OFF_W'(1);
    used     = wr_off_q - rd_off_q;
    full     = (used == OFF_W'(DEPTH));
    empty    = (used == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
    end else begin
      if (wr_adv) wr_off_q <= wr_off_d;
      if (rd_adv) rd_off_q <= rd_off_d;
    end
  end

  // slot index -> byte address; shift when the slot size allows it
  generate
    if (ENTRY_POW2) begin : g_shift
      assign wr_addr = base + (ADDR_W'(wr_off_q[DEPTH_LOG2-1:0]) << ENTRY_SH);
      assign rd_addr = base + (ADDR_W'(rd_off_q[DEPTH_LOG2-1:0]) << ENTRY_SH);
    end else begin : g_mult
      assign wr_addr = base + ADDR_W'(wr_off_q[DEPTH_LOG2-1:0]) * ADDR_W'(ENTRY_BYTES);
      assign rd_addr = base + ADDR_W'(rd_off_q[DEPTH_LOG2-1:0]) * ADDR_W'(ENTRY_BYTES);
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= OFF_W'(DEPTH)); // R10
  AST_WRITE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_adv |-> !full); // R10
  AST_READ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |-> !empty); // R6
endmodule

// File: rtl/spill_ctrl.sv
module spill_ctrl #(
  parameter int QD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [QD_W-1:0] q_depth,
  input  logic [QD_W-1:0] hi_thresh,
  input  logic [QD_W-1:0] lo_thresh,
  input  logic            full,
  input  logic            empty,
  input  logic            rsp_valid,
  output logic            do_write,
  output logic            do_read,
  output logic            do_drop,
  output logic            do_fwd_local,
  output logic            do_fwd_remote,
  output logic            spilling
);
  logic spill_q, spill_d;
  logic drain_q, drain_d;
  logic out_q, out_d;
  logic to_ring, drain_ok;

  always_comb begin
    to_ring       = spill_q || (q_depth >= hi_thresh);
    do_fwd_local  = in_valid && !to_ring;
    do_write      = in_valid && to_ring && !full;
    do_drop       = in_valid && to_ring && full;
    do_fwd_remote = rsp_valid && out_q;
    drain_ok      = drain_q || (q_depth <= lo_thresh);
    // a write owns the request port this cycle; the read retries next cycle
    do_read       = spill_q && drain_ok && !empty && !out_q && !do_write;

    spill_d = spill_q || (in_valid && to_ring);
    if (spill_q && empty && !out_q && !do_write) spill_d = 1'b0;
    drain_d = spill_d && drain_ok;

    out_d = out_q;
    if (do_read)            out_d = 1'b1;
    else if (do_fwd_remote) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spill_q <= 1'b0;
      drain_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      spill_q <= spill_d;
      drain_q <= drain_d;
      out_q   <= out_d;
    end
  end

  assign spilling = spill_q;

  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !spill_q |-> empty); // R11
  AST_READ_IN_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> spill_q); // R7
endmodule

// File: rtl/spill_req_fmt.sv
module spill_req_fmt
  import spill_pkg::*;
#(
  parameter int ID_W        = 16,
  parameter int LEN_W       = 12,
  parameter int ADDR_W      = 32,
  parameter int QPN_W       = 24,
  parameter int KEY_W       = 32,
  parameter int ENTRY_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_write,
  input  logic              do_read,
  input  logic              do_drop,
  input  logic              do_fwd_local,
  input  logic              do_fwd_remote,
  input  logic [ID_W-1:0]   in_pkt_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ID_W-1:0]   rsp_pkt_id,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [QPN_W-1:0]  qpn,
  input  logic [KEY_W-1:0]  rkey,
  output logic              req_valid,
  output logic              req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [QPN_W-1:0]  req_qpn,
  output logic [KEY_W-1:0]  req_rkey,
  output logic [ID_W-1:0]   req_pkt_id,
  output logic [LEN_W-1:0]  req_len,
  output logic              fwd_valid,
  output logic [ID_W-1:0]   fwd_pkt_id,
  output logic [LEN_W-1:0]  fwd_len,
  output logic              fwd_remote,
  output logic              drop_pulse
);
  localparam logic [LEN_W-1:0] SLOT_LEN = LEN_W'(ENTRY_BYTES);

  logic              req_en, fwd_en;
  rdma_op_e          op_d, op_q;
  logic [ADDR_W-1:0] addr_d;
  logic [ID_W-1:0]   rid_d, fid_d;
  logic [LEN_W-1:0]  rlen_d, flen_d;

  always_comb begin
    req_en = do_write || do_read;
    fwd_en = do_fwd_local || do_fwd_remote;
    op_d   = do_read ? OP_READ : OP_WRITE;
    addr_d = do_read ? rd_addr : wr_addr;
    rid_d  = do_read ? '0 : in_pkt_id;
    rlen_d = do_read ? SLOT_LEN : in_len;
    fid_d  = do_fwd_remote ? rsp_pkt_id : in_pkt_id;
    flen_d = do_fwd_remote ? rsp_len : in_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      fwd_valid  <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      req_valid  <= req_en;
      fwd_valid  <= fwd_en;
      drop_pulse <= do_drop;
    end
  end

  // payload registers: no reset, loaded only under their enables
  always_ff @(posedge clk) begin
    if (req_en) begin
      op_q       <= op_d;
      req_addr   <= addr_d;
      req_qpn    <= qpn;
      req_rkey   <= rkey;
      req_pkt_id <= rid_d;
      req_len    <= rlen_d;
    end
    if (fwd_en) begin
      fwd_pkt_id <= fid_d;
      fwd_len    <= flen_d;
      fwd_remote <= do_fwd_remote;
    end
  end

  assign req_op = op_q;

  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_READ) |=> !(req_valid && req_op == OP_READ)); // R7
  AST_FWD_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_fwd_local && do_fwd_remote)); // R11
  AST_REQ_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_write && do_read)); // R8
endmodule

// File: rtl/spill_ring_ctrl.sv
module spill_ring_ctrl #(
  parameter int ID_W        = 16,
  parameter int LEN_W       = 12,
  parameter int QD_W        = 16,
  parameter int ADDR_W      = 32,
  parameter int QPN_W       = 24,
  parameter int KEY_W       = 32,
  parameter int DEPTH_LOG2  = 4,
  parameter int ENTRY_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_pkt_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [QD_W-1:0]   q_depth,
  input  logic [QD_W-1:0]   cfg_hi_thresh,
  input  logic [QD_W-1:0]   cfg_lo_thresh,
  input  logic [ADDR_W-1:0] cfg_base_addr,
  input  logic [QPN_W-1:0]  cfg_qpn,
  input  logic [KEY_W-1:0]  cfg_rkey,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_pkt_id,
  input  logic [LEN_W-1:0]  rsp_len,
  output logic              req_valid,
  output logic              req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [QPN_W-1:0]  req_qpn,
  output logic [KEY_W-1:0]  req_rkey,
  output logic [ID_W-1:0]   req_pkt_id,
  output logic [LEN_W-1:0]  req_len,
  output logic              fwd_valid,
  output logic [ID_W-1:0]   fwd_pkt_id,
  output logic [LEN_W-1:0]  fwd_len,
  output logic              fwd_remote,
  output logic              drop_pulse
);
  logic              full, empty, spilling;
  logic              do_write, do_read, do_drop, do_fwd_local, do_fwd_remote;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  spill_ctrl #(.QD_W(QD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .q_depth(q_depth),
    .hi_thresh(cfg_hi_thresh), .lo_thresh(cfg_lo_thresh),
    .full(full), .empty(empty), .rsp_valid(rsp_valid),
    .do_write(do_write), .do_read(do_read), .do_drop(do_drop),
    .do_fwd_local(do_fwd_local), .do_fwd_remote(do_fwd_remote),
    .spilling(spilling)
  );

  spill_ring_ptr #(.DEPTH_LOG2(DEPTH_LOG2), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_adv(do_write), .rd_adv(do_read),
    .base(cfg_base_addr), .full(full), .empty(empty),
    .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  spill_req_fmt #(.ID_W(ID_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .QPN_W(QPN_W),
                  .KEY_W(KEY_W), .ENTRY_BYTES(ENTRY_BYTES)) u_fmt (
    .clk(clk), .rst_n(rst_n), .do_write(do_write), .do_read(do_read),
    .do_drop(do_drop), .do_fwd_local(do_fwd_local), .do_fwd_remote(do_fwd_remote),
    .in_pkt_id(in_pkt_id), .in_len(in_len), .rsp_pkt_id(rsp_pkt_id), .rsp_len(rsp_len),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .qpn(cfg_qpn), .rkey(cfg_rkey),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_qpn(req_qpn),
    .req_rkey(req_rkey), .req_pkt_id(req_pkt_id), .req_len(req_len),
    .fwd_valid(fwd_valid), .fwd_pkt_id(fwd_pkt_id), .fwd_len(fwd_len),
    .fwd_remote(fwd_remote), .drop_pulse(drop_pulse)
  );

  AST_REMOTE_IN_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_remote) |-> spilling); // R9
endmodule

// File: tb/spill_ring_ctrl_bench.sv
module spill_ring_ctrl_bench;
  localparam int ID_W = 16, LEN_W = 12, QD_W = 16, ADDR_W = 32, QPN_W = 24, KEY_W = 32;
  localparam int DEPTH_LOG2 = 2, ENTRY_BYTES = 2048, DEPTH = 4;
  localparam logic [ADDR_W-1:0] BASE = 32'h4000_0000;
  localparam logic [QPN_W-1:0]  QPN  = 24'h000A5C;
  localparam logic [KEY_W-1:0]  RKEY = 32'h1234_5678;
  localparam int HI = 8, LO = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [ID_W-1:0] in_pkt_id = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic [QD_W-1:0] q_depth = '0;
  logic rsp_valid = 1'b0;
  logic [ID_W-1:0] rsp_pkt_id = '0;
  logic [LEN_W-1:0] rsp_len = '0;
  logic req_valid, req_op, fwd_valid, fwd_remote, drop_pulse;
  logic [ADDR_W-1:0] req_addr;
  logic [QPN_W-1:0] req_qpn;
  logic [KEY_W-1:0] req_rkey;
  logic [ID_W-1:0] req_pkt_id, fwd_pkt_id;
  logic [LEN_W-1:0] req_len, fwd_len;

  always #2 clk = ~clk;

  spill_ring_ctrl #(.ID_W(ID_W), .LEN_W(LEN_W), .QD_W(QD_W), .ADDR_W(ADDR_W), .QPN_W(QPN_W),
                    .KEY_W(KEY_W), .DEPTH_LOG2(DEPTH_LOG2), .ENTRY_BYTES(ENTRY_BYTES)) u_spill_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt_id(in_pkt_id), .in_len(in_len),
    .q_depth(q_depth), .cfg_hi_thresh(QD_W'(HI)), .cfg_lo_thresh(QD_W'(LO)),
    .cfg_base_addr(BASE), .cfg_qpn(QPN), .cfg_rkey(RKEY),
    .rsp_valid(rsp_valid), .rsp_pkt_id(rsp_pkt_id), .rsp_len(rsp_len),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_qpn(req_qpn),
    .req_rkey(req_rkey), .req_pkt_id(req_pkt_id), .req_len(req_len),
    .fwd_valid(fwd_valid), .fwd_pkt_id(fwd_pkt_id), .fwd_len(fwd_len),
    .fwd_remote(fwd_remote), .drop_pulse(drop_pulse)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed { logic [ID_W-1:0] id; logic [LEN_W-1:0] len; } pkt_t;
  pkt_t order_q[$];
  bit m_spill = 0, m_drain = 0, m_out = 0;
  int wcnt = 0, rcnt = 0;
  bit e_req_v = 0, e_op = 0, e_fwd_v = 0, e_rem = 0, e_drop = 0;
  longint e_addr = 0, e_rid = 0, e_rlen = 0, e_fid = 0, e_flen = 0;
  string req_tag = "R3", fwd_tag = "R2";

  always @(posedge clk) begin
    bit full, empty, route, wr, rd, ns, dok;
    if (!rst_n) begin
      m_spill = 0; m_drain = 0; m_out = 0; wcnt = 0; rcnt = 0;
      e_req_v = 0; e_fwd_v = 0; e_drop = 0;
    end else begin
      e_req_v = 0; e_fwd_v = 0; e_drop = 0; req_tag = "R3"; fwd_tag = "R2";
      full  = (wcnt - rcnt) == DEPTH;
      empty = (wcnt == rcnt);
      route = m_spill || (int'(q_depth) >= HI);
      wr = 0;
      if (in_valid) begin
        if (!route) begin
          e_fwd_v = 1; e_rem = 0; e_fid = in_pkt_id; e_flen = in_len; fwd_tag = "R2";
          order_q.push_back({in_pkt_id, in_len});
        end else if (full) begin
          e_drop = 1;
        end else begin
          e_req_v = 1; e_op = 0; e_addr = BASE + (wcnt % DEPTH) * ENTRY_BYTES;
          e_rid = in_pkt_id; e_rlen = in_len; req_tag = m_spill ? "R5" : "R3";
          order_q.push_back({in_pkt_id, in_len});
          wcnt++; wr = 1;
        end
      end
      if (rsp_valid) begin
        fwd_tag = "R9";
        if (m_out) begin
          e_fwd_v = 1; e_rem = 1; e_fid = rsp_pkt_id; e_flen = rsp_len;
        end
      end
      dok = m_drain || (int'(q_depth) <= LO);
      rd = m_spill && dok && !empty && !m_out && !wr;
      if (m_spill && dok && !empty && !m_out && wr) req_tag = "R8";
      if (rd) begin
        e_req_v = 1; e_op = 1; e_addr = BASE + (rcnt % DEPTH) * ENTRY_BYTES;
        e_rid = 0; e_rlen = ENTRY_BYTES; req_tag = m_drain ? "R7" : "R6";
        rcnt++;
      end
      ns = m_spill || (in_valid && route);
      if (m_spill && empty && !m_out && !wr) ns = 0;
      if (rd) m_out = 1; else if (rsp_valid && m_out) m_out = 0;
      m_drain = ns && dok;
      m_spill = ns;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_valid === e_req_v, req_tag, "req_valid", req_valid, e_req_v);
      if (req_valid && e_req_v) begin
        check(req_op === e_op, req_tag, "req_op", req_op, e_op);
        check(req_addr === e_addr[ADDR_W-1:0], "R4", "req_addr", req_addr, e_addr);
        check(req_pkt_id === e_rid[ID_W-1:0], req_tag, "req_pkt_id", req_pkt_id, e_rid);
        check(req_len === e_rlen[LEN_W-1:0], req_tag, "req_len", req_len, e_rlen);
        check(req_qpn === QPN && req_rkey === RKEY, "R3", "req_qpn/rkey", req_rkey, RKEY);
      end
      check(fwd_valid === e_fwd_v, fwd_tag, "fwd_valid", fwd_valid, e_fwd_v);
      if (fwd_valid && e_fwd_v) begin
        check(fwd_remote === e_rem, fwd_tag, "fwd_remote", fwd_remote, e_rem);
        check(fwd_pkt_id === e_fid[ID_W-1:0] && fwd_len === e_flen[LEN_W-1:0],
              fwd_tag, "fwd_pkt_id", fwd_pkt_id, e_fid);
      end
      check(drop_pulse === e_drop, "R10", "drop_pulse", drop_pulse, e_drop);
      if (fwd_valid) begin
        if (order_q.size() == 0) check(0, "R11", "order (nothing pending)", fwd_pkt_id, 0);
        else begin
          pkt_t p;
          p = order_q.pop_front();
          check(fwd_pkt_id === p.id, "R11", "arrival order", fwd_pkt_id, p.id);
        end
      end
    end
  end

  // ---------------- remote memory responder ----------------
  logic [ID_W+LEN_W-1:0] mem [logic [ADDR_W-1:0]];
  int rsp_lat = 3, cnt = 0;
  bit pend = 0, stray_go = 0;
  logic [ID_W+LEN_W-1:0] pend_data = '0;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        rsp_valid = 1'b1; {rsp_pkt_id, rsp_len} = pend_data; pend = 0;
      end else cnt--;
    end else if (stray_go) begin
      rsp_valid = 1'b1; rsp_pkt_id = 16'hBEEF; rsp_len = 12'd99; stray_go = 0;
    end
    if (rst_n && req_valid) begin
      if (req_op == 1'b0) mem[req_addr] = {req_pkt_id, req_len};
      else begin
        pend = 1; cnt = rsp_lat;
        pend_data = mem.exists(req_addr) ? mem[req_addr] : '0;
      end
    end
  end

  // ---------------- stimulus ----------------
  int next_id = 1;
  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_pkt_id = ID_W'(next_id); in_len = LEN_W'(60 + next_id * 13);
      next_id++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      check(0, "R11", "watchdog expired", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R1: outputs quiet during reset
    check(req_valid === 1'b0 && fwd_valid === 1'b0 && drop_pulse === 1'b0,
          "R1", "outputs in reset", {req_valid, fwd_valid, drop_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid === 1'b0 && fwd_valid === 1'b0 && drop_pulse === 1'b0,
          "R1", "outputs after reset", {req_valid, fwd_valid, drop_pulse}, 0);

    // R2: local bypass
    q_depth = 5; send(3); idle(3);
    // R9: stray response ignored
    stray_go = 1; idle(4);

    // R3/R5: enter spill, keep writing below threshold
    q_depth = 10; send(1);
    q_depth = 5;  send(2); idle(2);
    // R6/R7/R8: drain, with arrivals competing for the request port
    q_depth = 2; idle(1); send(3);
    q_depth = 6; idle(2); send(1);
    idle(40);
    // R11: back to local
    q_depth = 5; send(2); idle(4);

    // R10: fill the ring and drop
    q_depth = 20; send(6); idle(4);
    rsp_lat = 0; q_depth = 1; idle(1); send(2);
    rsp_lat = 5; send(1); idle(60);
    q_depth = 4; send(1); idle(4);

    // second wrap with alternating latency
    q_depth = 9; send(4);
    q_depth = 3; rsp_lat = 1; send(3); idle(50);
    q_depth = 0; send(2); idle(5);

    check(order_q.size() == 0, "R11", "all packets delivered", order_q.size(), 0);
    finish_run();
  end
endmodule